// File: doc/BRIEF.md
# Multi-Rail Reset Generator with Manual Reset

This block merges the health of several supply rails into a single active-low system reset. For every channel it receives a rail-above-threshold flag, a channel enable and the channel's power-good output. It also takes an active-low manual-reset request and an undervoltage-lockout flag. The system reset is pulled low as soon as a fault is confirmed. It is released only after a timeout, counted in clock cycles, during which every release condition has stayed good without a break.

Three timeout modes are available through a 2-bit select:
- a long fixed default;
- a programmable timeout, which is a short internal minimum plus an extension taken from an input;
- a bypass mode, which releases after only a short propagation delay.

A rail dip must last a set number of cycles before it counts as a fault. A manual-reset pulse must also last a set number of cycles, so shorter glitches are rejected. The manual-reset input is assumed to be already synchronised to the clock.

Top module: `multi_rail_rst_gen`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is 0. After `rst_n` rises, `sys_rst_n` stays 0 until a full timeout has been counted.
- R2: The release condition is: every bit of `rail_ok`, `chan_en` and `chan_pg` is 1, `mr_n` is 1 and `uvlo` is 0. `sys_rst_n` rises at the clock edge that completes exactly T consecutive cycles in which this condition held, and not earlier.
- R3: T is set by `tmo_mode`:
  - 2'b00 gives T = FIXED_CYCLES;
  - 2'b01 gives T = MIN_CYCLES + `tmo_ext`;
  - 2'b10 (bypass) gives T = BYPASS_CYCLES;
  - 2'b11 behaves as 2'b00.
- R4: Any break in the release condition during the count restarts it from zero. Release then needs T further good cycles.
- R5: A 0 on any `chan_en` bit drives `sys_rst_n` low at the next clock edge.
- R6: A single `rail_ok` bit that stays 0 for PROP_CYCLES consecutive cycles drives `sys_rst_n` low at the edge that completes those cycles. A shorter dip leaves a released reset high.
- R7: `mr_n` held 0 for MR_FILT_CYCLES consecutive cycles drives `sys_rst_n` low at the edge that completes them. A shorter low pulse leaves a released reset high.
- R8: `uvlo` at 1 drives `sys_rst_n` low at the next edge and holds it low, whatever the other inputs are.
- R9: A 0 on a `chan_pg` bit does not pull a released reset low. While reset is low, it does block release.
- R10: The count is cleared when reset is released. Any later assertion therefore needs a complete new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rail_ok | input | NUM_CH | Per-channel rail-above-threshold flag |
| chan_en | input | NUM_CH | Per-channel enable, active high |
| chan_pg | input | NUM_CH | Per-channel power-good output |
| mr_n | input | 1 | Manual reset request, active low, already synchronised |
| uvlo | input | 1 | Undervoltage lockout, active high |
| tmo_mode | input | 2 | Timeout mode select |
| tmo_ext | input | EXT_W | Extension cycles added in programmable mode |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
If the release counter is left in a wrong state, it shows up as `sys_rst_n` rising too early or too late. The error is visible at the end of the very next timeout window, so every release is checked at the exact cycle of its edge and at the cycle before it. A persistence filter that is stuck or miscounting shows up as a glitch that is wrongly acted on, or as a reset that drops one cycle off its expected edge. Both cases are checked within PROP_CYCLES or MR_FILT_CYCLES cycles of the stimulus. A wrongly decoded mode shows up as a release time that matches a different mode.

// File: rtl/rrg_pkg.sv
// Shared types for the multi-rail reset generator.
package rrg_pkg;
    typedef enum logic [1:0] {
        TMO_FIXED  = 2'b00,
        TMO_PROG   = 2'b01,
        TMO_BYPASS = 2'b10,
        TMO_RSVD   = 2'b11
    } tmo_mode_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } rst_state_e;
endpackage

// File: rtl/rrg_persist.sv
// Persistence filter.
// Raises 'trip' in the cycle in which 'bad' has been high for LEN
// consecutive sampled cycles, counting that cycle, and keeps it high while
// 'bad' stays high. Any cycle with 'bad' low clears the count.
// Assumes LEN >= 1.
module rrg_persist #(
    parameter int LEN = 4,
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bad,
    output logic trip
);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive bad cycles, saturating at LEN-1.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (!bad)           run_cnt <= '0;
        else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
    end

    // The fault is confirmed on the LEN-th consecutive bad cycle.
    assign trip = bad && (run_cnt == LAST);
endmodule

// File: rtl/rrg_tmo_sel.sv
// Timeout selector.
// Maps the 2-bit mode select to a release timeout in clock cycles.
// The reserved code falls back to the fixed default.
// Assumes CNT_W is wide enough for MIN_CYCLES plus the largest extension.
module rrg_tmo_sel
    import rrg_pkg::*;
#(
    parameter int CNT_W         = 25,
    parameter int EXT_W         = 20,
    parameter int FIXED_CYCLES  = 19_000_000,
    parameter int MIN_CYCLES    = 3_500,
    parameter int BYPASS_CYCLES = 3_500
) (
    input  logic [1:0]       mode,
    input  logic [EXT_W-1:0] ext,
    output logic [CNT_W-1:0] limit
);
    // Decode the mode into a cycle count.
    always_comb begin
        unique case (tmo_mode_e'(mode))
            TMO_PROG:   limit = CNT_W'(MIN_CYCLES) + CNT_W'(ext);
            TMO_BYPASS: limit = CNT_W'(BYPASS_CYCLES);
            default:    limit = CNT_W'(FIXED_CYCLES);
        endcase
    end
endmodule

// File: rtl/rrg_seq.sv
// Reset sequencer.
// HOLD keeps reset low and counts consecutive good cycles. RUN keeps reset
// high until an assert request arrives. The counter is cleared on every
// state change and on any non-good cycle.
// Assumes an assert request is never raised while 'good' is high.
module rrg_seq
    import rrg_pkg::*;
#(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             good,
    input  logic             assert_req,
    input  logic [CNT_W-1:0] limit,
    output logic             rel
);
    rst_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    // One more good cycle, held one bit wider so it cannot wrap.
    assign cnt_next = {1'b0, cnt} + 1'b1;

    // State and good-cycle counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (!good) begin
                        cnt <= '0;
                    end else if (cnt_next >= {1'b0, limit}) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_next[CNT_W-1:0];
                    end
                end
                ST_RUN: begin
                    if (assert_req) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end
                end
                default: begin
                    state <= ST_HOLD;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign rel = (state == ST_RUN);
endmodule

// File: rtl/multi_rail_rst_gen.sv
// Multi-rail reset generator, top level.
// Merges per-channel rail flags, enables and power-good outputs, a manual
// reset request and an undervoltage-lockout flag into one active-low
// system reset.
// Assumes:
//   - mr_n is synchronised to clk;
//   - NUM_CH is between 2 and 4;
//   - CNT_W covers FIXED_CYCLES and MIN_CYCLES plus the largest tmo_ext.
module multi_rail_rst_gen #(
    parameter int NUM_CH         = 4,
    parameter int CNT_W          = 25,
    parameter int EXT_W          = 20,
    parameter int FIXED_CYCLES   = 19_000_000,
    parameter int MIN_CYCLES     = 3_500,
    parameter int BYPASS_CYCLES  = 3_500,
    parameter int PROP_CYCLES    = 3_500,
    parameter int MR_FILT_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rail_ok,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] chan_pg,
    input  logic              mr_n,
    input  logic              uvlo,
    input  logic [1:0]        tmo_mode,
    input  logic [EXT_W-1:0]  tmo_ext,
    output logic              sys_rst_n
);
    logic [NUM_CH-1:0] rail_trip;
    logic              mr_trip;
    logic              all_good;
    logic              assert_req;
    logic [CNT_W-1:0]  limit;

    // One persistence filter per rail, so each dip is judged on its own.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rail
        rrg_persist #(.LEN(PROP_CYCLES)) u_rail_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .bad  (!rail_ok[ch]),
            .trip (rail_trip[ch])
        );
    end

    // Manual-reset glitch filter, counted in clock cycles.
    rrg_persist #(.LEN(MR_FILT_CYCLES)) u_mr_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .bad  (!mr_n),
        .trip (mr_trip)
    );

    // Release needs every condition good at once.
    assign all_good = (&rail_ok) && (&chan_en) && (&chan_pg) && mr_n && !uvlo;

    // Confirmed faults that pull a released reset low.
    // Power-good alone is not among them.
    assign assert_req = uvlo || !(&chan_en) || (|rail_trip) || mr_trip;

    // Timeout selected by mode.
    rrg_tmo_sel #(
        .CNT_W        (CNT_W),
        .EXT_W        (EXT_W),
        .FIXED_CYCLES (FIXED_CYCLES),
        .MIN_CYCLES   (MIN_CYCLES),
        .BYPASS_CYCLES(BYPASS_CYCLES)
    ) u_tmo (
        .mode (tmo_mode),
        .ext  (tmo_ext),
        .limit(limit)
    );

    // Hold/release sequencer.
    rrg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .good      (all_good),
        .assert_req(assert_req),
        .limit     (limit),
        .rel       (sys_rst_n)
    );
endmodule

// File: rtl/rrg_checker.sv
// Port-level checker for multi_rail_rst_gen, attached by bind.
// Assumes the same NUM_CH as the instance it is bound to.
module rrg_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] rail_ok,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] chan_pg,
    input logic              mr_n,
    input logic              uvlo,
    input logic              sys_rst_n
);
    logic cond_good;
    logic no_fault_src;

    // Release condition as seen at the ports.
    assign cond_good    = (&rail_ok) && (&chan_en) && (&chan_pg) && mr_n && !uvlo;
    // Every asserting source idle; power-good deliberately left out.
    assign no_fault_src = (&rail_ok) && (&chan_en) && mr_n && !uvlo;

    // R1: reset is still low in the first cycle after block reset.
    assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sys_rst_n);

    // R2: reset never rises out of a cycle where the condition was bad.
    assert_release_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_n && !cond_good) |=> !sys_rst_n);

    // R5: a disabled channel forces reset low at the next edge.
    assert_enable_forces_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(&chan_en) |=> !sys_rst_n);

    // R8: lockout forces reset low at the next edge.
    assert_uvlo_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !sys_rst_n);

    // R9: with no fault source present, a released reset stays released.
    assert_pg_no_assert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && no_fault_src) |=> sys_rst_n);
endmodule

bind multi_rail_rst_gen rrg_checker #(.NUM_CH(NUM_CH)) u_rrg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rail_ok  (rail_ok),
    .chan_en  (chan_en),
    .chan_pg  (chan_pg),
    .mr_n     (mr_n),
    .uvlo     (uvlo),
    .sys_rst_n(sys_rst_n)
);

// File: tb/multi_rail_rst_gen_tb.sv
// Scoreboard bench for multi_rail_rst_gen.
// Drivers change inputs on the falling edge and queue the expected
// sys_rst_n value for a given cycle. A monitor compares it on the
// falling edge of that cycle.
module multi_rail_rst_gen_tb;
    localparam int NCH   = 3;
    localparam int CW    = 16;
    localparam int EW    = 8;
    localparam int FIX   = 40;
    localparam int MINC  = 8;
    localparam int BYP   = 3;
    localparam int PROP  = 4;
    localparam int MRF   = 5;
    localparam int WDOG  = 100_000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] rail_ok, chan_en, chan_pg;
    logic           mr_n, uvlo;
    logic [1:0]     tmo_mode;
    logic [EW-1:0]  tmo_ext;
    logic           sys_rst_n;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc      = 0;
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    multi_rail_rst_gen #(
        .NUM_CH(NCH), .CNT_W(CW), .EXT_W(EW), .FIXED_CYCLES(FIX),
        .MIN_CYCLES(MINC), .BYPASS_CYCLES(BYP), .PROP_CYCLES(PROP),
        .MR_FILT_CYCLES(MRF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .chan_en(chan_en),
        .chan_pg(chan_pg), .mr_n(mr_n), .uvlo(uvlo), .tmo_mode(tmo_mode),
        .tmo_ext(tmo_ext), .sys_rst_n(sys_rst_n)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Count rising edges.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].cyc == cyc) begin
                checks++;
                if (sys_rst_n !== sb_q[i].val) begin
                    failures++;
                    $display("FAIL %s: sys_rst_n=%b expected %b at cycle %0d",
                             sb_q[i].tag, sys_rst_n, sb_q[i].val, cyc);
                end
                sb_q.delete(i);
            end
        end
    end

    // Queue an expected value for d cycles from now.
    task automatic expect_at(input int d, input logic v, input string tag);
        sb_q.push_back('{cyc + d, v, tag});
    endtask

    // Move forward n falling edges.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        wait (cyc >= WDOG);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: cycle=%0d expected completion before %0d", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        rail_ok  = '1;
        chan_en  = '1;
        chan_pg  = '1;
        mr_n     = 1'b1;
        uvlo     = 1'b0;
        tmo_mode = 2'b00;
        tmo_ext  = '0;
        step(1);

        // R1: low during block reset and for the full timeout after it.
        expect_at(1, 1'b0, "R1 in reset");
        expect_at(3, 1'b0, "R1 in reset");
        step(4);
        rst_n = 1'b1;
        expect_at(1, 1'b0, "R1 after reset");
        expect_at(FIX - 1, 1'b0, "R2 one cycle early");
        expect_at(FIX, 1'b1, "R3 fixed release");
        step(FIX + 1);

        // R9: losing power-good does not pull a released reset low.
        chan_pg[1] = 1'b0;
        expect_at(1, 1'b1, "R9 pg low");
        expect_at(5, 1'b1, "R9 pg low");
        step(5);
        chan_pg[1] = 1'b1;
        step(1);

        // R6: a rail dip shorter than PROP is ignored.
        rail_ok[0] = 1'b0;
        for (int d = 1; d <= PROP + 1; d++) expect_at(d, 1'b1, "R6 short dip");
        step(PROP - 1);
        rail_ok[0] = 1'b1;
        step(3);

        // R6: a rail held low for PROP cycles asserts reset.
        rail_ok[0] = 1'b0;
        expect_at(PROP - 1, 1'b1, "R6 before trip");
        expect_at(PROP, 1'b0, "R6 trip");
        step(PROP);
        // R3: programmable mode, T = MIN + ext.
        rail_ok[0] = 1'b1;
        tmo_mode   = 2'b01;
        tmo_ext    = 8'd5;
        expect_at(MINC + 5 - 1, 1'b0, "R3 prog early");
        expect_at(MINC + 5, 1'b1, "R3 prog release");
        step(MINC + 6);

        // R5, then R4: a one-cycle break restarts the count.
        chan_en[2] = 1'b0;
        expect_at(1, 1'b0, "R5 enable low");
        step(2);
        chan_en[2] = 1'b1;
        step(6);
        chan_pg[0] = 1'b0;
        expect_at(1, 1'b0, "R4 break");
        step(1);
        chan_pg[0] = 1'b1;
        expect_at(MINC + 5 - 1, 1'b0, "R4 restart early");
        expect_at(MINC + 5, 1'b1, "R4 restart release");
        step(MINC + 6);

        // R7: a manual-reset pulse shorter than MRF is rejected.
        mr_n = 1'b0;
        for (int d = 1; d <= MRF; d++) expect_at(d, 1'b1, "R7 short pulse");
        step(MRF - 1);
        mr_n = 1'b1;
        step(2);

        // R7: a manual-reset pulse of MRF cycles asserts reset.
        mr_n = 1'b0;
        expect_at(MRF - 1, 1'b1, "R7 before trip");
        expect_at(MRF, 1'b0, "R7 trip");
        expect_at(14, 1'b0, "R7 held");
        step(15);
        // R3: bypass mode releases after BYP cycles.
        mr_n     = 1'b1;
        tmo_mode = 2'b10;
        expect_at(BYP - 1, 1'b0, "R3 bypass early");
        expect_at(BYP, 1'b1, "R3 bypass release");
        step(BYP + 1);

        // R8: lockout overrides everything.
        uvlo = 1'b1;
        expect_at(1, 1'b0, "R8 uvlo");
        expect_at(50, 1'b0, "R8 uvlo held");
        step(50);
        // R3: the reserved code uses the fixed timeout.
        uvlo     = 1'b0;
        tmo_mode = 2'b11;
        expect_at(FIX - 1, 1'b0, "R3 reserved early");
        expect_at(FIX, 1'b1, "R3 reserved release");
        step(FIX + 1);

        // R10: after a release, the next release takes the full timeout.
        tmo_mode   = 2'b00;
        chan_en[0] = 1'b0;
        expect_at(1, 1'b0, "R10 re-assert");
        step(1);
        chan_en[0] = 1'b1;
        expect_at(FIX - 1, 1'b0, "R10 full timeout early");
        expect_at(FIX, 1'b1, "R10 full timeout release");
        step(FIX + 1);

        wait (sb_q.size() == 0);
        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule